// File: doc/BRIEF.md
# Compare/PWM Timer Channel

This block is a single timer channel with its own 16-bit up-counter. The counter runs from zero up to a programmable modulus, wraps back to zero, and flags each wrap. The channel compares the counter against an active 16-bit channel value. In compare mode, a match sets, clears or toggles the output pin. In edge-aligned PWM mode, the pin holds its active level from the start of each period until the match, then its inactive level until the period ends.

Software reaches the block through a write-only byte bus. The 16-bit channel value is loaded one byte at a time into a holding buffer. It becomes active only when both bytes have arrived. In PWM mode the load also waits until the counter returns to zero, so a running period is never cut short. A sticky match flag drives an interrupt request when the request is enabled.

Register map (3-bit address, 8-bit data):
- 0: modulus low byte
- 1: modulus high byte
- 2: control register. Bits [1:0] select the compare action, bit 2 selects PWM mode, bit 3 selects PWM polarity, bit 4 enables the interrupt.
- 3: status register. Writing 1 to bit 0 clears the flag.
- 4: channel value low byte
- 5: channel value high byte

Top module: `cmp_pwm_chan`

## Requirements
- R1: The counter advances by one each clock. After the cycle in which it equals the modulus, it returns to 0. `ovf_o` is high exactly in the cycles where the counter equals the modulus.
- R2: In compare mode (control bit 2 = 0), a cycle in which the counter equals the active value updates the pin on the next cycle according to control bits [1:0]: 01 toggles it, 10 drives it low, 11 drives it high, 00 leaves it unchanged.
- R3: A match sets `flag_o` on the next cycle. Writing status bit 0 = 1 clears the flag. A match in the same cycle as the clear wins.
- R4: `irq_o` is high exactly when `flag_o` is high and control bit 4 is set.
- R5: In compare mode, the buffered value becomes active on the edge after the second of its two bytes is written, in either order. A single byte leaves the active value unchanged.
- R6: A write to the control register discards a half-written byte pair, so a later write of the other byte alone does not load a value.
- R7: In PWM mode, the pin in each cycle reflects the previous cycle's counter. It takes the active level (high when control bit 3 = 0, low when it is 1) while that counter was below the active value, and the inactive level otherwise.
- R8: In PWM mode, an active value of 0 gives a constant inactive pin (0% duty). An active value above the modulus gives a constant active pin (100% duty).
- R9: In PWM mode, a complete byte pair loads only on the clock edge at which the counter wraps from the modulus to 0. The period already in progress keeps its old duty.
- R10: While reset is held, the counter, modulus, values, buffers and flag are zero, and the pin is low (inactive for polarity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| cnt_o | output | 16 | Current counter value |
| ovf_o | output | 1 | Counter is at the modulus and wraps next |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Channel output pin |

## Verification
Three PWM settings are tried with the modulus fixed:
- A value of zero shows that the 0% case never leaks an active cycle.
- A value above the modulus shows that 100% duty never drops for a cycle.
- A mid-period byte pair tells a load taken at the wrap apart from one taken on the spot. The old duty must still be visible after the second byte lands.

In compare mode, the bench writes the low byte, then a control write, then the high byte. This separates a pair that is correctly discarded from one that loads anyway, and the match-flag timing shows which value is active. A long random mix of byte writes, control changes, flag clears and modulus changes is then checked every cycle against a bench model. The model covers the order of pairing bits, the set-over-clear priority of the flag, and all four compare actions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MOD0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_VAL0 = 3'd4;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;

  typedef struct packed {
    logic    ie;
    logic    pol;
    logic    pwm;
    oc_act_e act;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic oc_next(logic cur, oc_act_e a);
    case (a)
      ACT_TOGGLE: return ~cur;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  function automatic logic [CNT_W-1:0] cnt_step(logic [CNT_W-1:0] c,
                                                logic [CNT_W-1:0] m);
    return (c == m) ? '0 : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_step(cnt_q, mod_i);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == mod_i);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned NBYTE = 2,
  localparam int unsigned CNT_W = BUS_W * NBYTE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  input  logic                 xfer_i,
  output logic [CNT_W-1:0]     mod_o,
  output ctrl_t                ctrl_o,
  output logic [CNT_W-1:0]     buf_o,
  output logic                 pair_done_o,
  output logic                 flag_clr_o
);

  logic [BUS_W-1:0] mod_b [NBYTE];
  logic [BUS_W-1:0] val_b [NBYTE];
  logic [NBYTE-1:0] got_q;
  ctrl_t            ctrl_q;

  wire ctrl_hit = we_i && (addr_i == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (ctrl_hit) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    wire mod_hit = we_i && (addr_i == A_MOD0 + ADDR_W'(g));
    wire val_hit = we_i && (addr_i == A_VAL0 + ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mod_b[g] <= '0;
      else if (mod_hit) mod_b[g] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_b[g] <= '0;
      else if (val_hit) val_b[g] <= wdata_i;
    end

    // pairing bit: control write discards, byte write marks, load consumes
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        got_q[g] <= 1'b0;
      else if (ctrl_hit) got_q[g] <= 1'b0;
      else if (val_hit)  got_q[g] <= 1'b1;
      else if (xfer_i)   got_q[g] <= 1'b0;
    end

    assign mod_o[g*BUS_W +: BUS_W] = mod_b[g];
    assign buf_o[g*BUS_W +: BUS_W] = val_b[g];
  end

  assign ctrl_o      = ctrl_q;
  assign pair_done_o = &got_q;
  assign flag_clr_o  = we_i && (addr_i == A_STAT) && wdata_i[0];

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  oc_act_e          act_i,
  input  logic             pwm_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] buf_i,
  input  logic             pair_done_i,
  input  logic             flag_clr_i,
  output logic             xfer_o,
  output logic             match_o,
  output logic [CNT_W-1:0] cval_o,
  output logic             flag_o,
  output logic             pin_o
);

  function automatic logic pwm_level(logic [CNT_W-1:0] c,
                                     logic [CNT_W-1:0] v, logic pol);
    return (c < v) ? ~pol : pol;
  endfunction

  logic [CNT_W-1:0] cval_q;
  logic             flag_q;
  logic             pin_q;

  assign xfer_o  = pair_done_i && (pwm_i ? wrap_i : 1'b1);
  assign match_o = (cnt_i == cval_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cval_q <= '0;
    else if (xfer_o) cval_q <= buf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (match_o)    flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_q <= 1'b0;
    else if (pwm_i)   pin_q <= pwm_level(cnt_i, cval_q, pol_i);
    else if (match_o) pin_q <= oc_next(pin_q, act_i);
  end

  assign cval_o = cval_q;
  assign flag_o = flag_q;
  assign pin_o  = pin_q;

endmodule

// File: rtl/cmp_pwm_chan.sv
module cmp_pwm_chan
  import tmr_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              pin_o
);

  logic [CNT_W-1:0] mod_q, buf_q, cval_act, cnt_q;
  ctrl_t            ctrl_q;
  logic             pair_done, flag_clr, xfer_ev, match_ev, wrap_ev, flag_q;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mod_i(mod_q), .cnt_o(cnt_q), .wrap_o(wrap_ev)
  );

  tmr_regs #(.BUS_W(BUS_W), .NBYTE(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .xfer_i(xfer_ev), .mod_o(mod_q), .ctrl_o(ctrl_q),
    .buf_o(buf_q), .pair_done_o(pair_done), .flag_clr_o(flag_clr)
  );

  tmr_chan #(.CNT_W(CNT_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_q), .wrap_i(wrap_ev),
    .act_i(ctrl_q.act), .pwm_i(ctrl_q.pwm), .pol_i(ctrl_q.pol),
    .buf_i(buf_q), .pair_done_i(pair_done), .flag_clr_i(flag_clr),
    .xfer_o(xfer_ev), .match_o(match_ev), .cval_o(cval_act),
    .flag_o(flag_q), .pin_o(pin_o)
  );

  assign cnt_o  = cnt_q;
  assign ovf_o  = wrap_ev;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ctrl_q.ie;

endmodule

// File: rtl/cmp_pwm_chan_chk.sv
module cmp_pwm_chan_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             flag,
  input logic             irq,
  input logic             pin,
  input logic             match_ev,
  input logic             xfer_ev,
  input logic             pair_done,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] cval
);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> cnt == '0); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !ovf |=> cnt == $past(cnt) + 1'b1); // R1
  AST_OC_SET: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl.pwm && match_ev && ctrl.act == ACT_SET) |=> pin); // R2
  AST_OC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl.pwm && match_ev && ctrl.act == ACT_CLEAR) |=> !pin); // R2
  AST_OC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl.pwm && match_ev && ctrl.act == ACT_TOGGLE) |=> pin != $past(pin)); // R2
  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) match_ev |=> flag); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !flag |-> !irq); // R4
  AST_LOAD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) xfer_ev |-> pair_done); // R5
  AST_PWM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) (ctrl.pwm && cnt < cval) |=> pin != $past(ctrl.pol)); // R7
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n) (ctrl.pwm && cval == '0) |=> pin == $past(ctrl.pol)); // R8
  AST_PWM_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (ctrl.pwm && xfer_ev) |-> ovf); // R9

endmodule

bind cmp_pwm_chan cmp_pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .ovf(wrap_ev), .flag(flag_q),
  .irq(irq_o), .pin(pin_o), .match_ev(match_ev), .xfer_ev(xfer_ev),
  .pair_done(pair_done), .ctrl(ctrl_q), .cval(cval_act)
);

// File: tb/sim_cmp_pwm_chan.sv
`timescale 1ns/1ps
module sim_cmp_pwm_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] cnt_o;
  logic        ovf_o, flag_o, irq_o, pin_o;

  always #2.5 clk = ~clk;

  cmp_pwm_chan u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_o(cnt_o), .ovf_o(ovf_o), .flag_o(flag_o),
    .irq_o(irq_o), .pin_o(pin_o)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  chk_on = 1'b0;
  bit  done = 1'b0;

  task automatic check(bit ok, string req, longint got, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // ---------------- bench reference model, built from the requirements
  logic [15:0] m_cnt, m_mod, m_act;
  logic [7:0]  m_lo, m_hi;
  logic [4:0]  m_ctl;
  logic        m_glo, m_ghi, m_flag, m_pin;

  function automatic logic act_apply(logic p, logic [1:0] a);
    if (a == 2'b11) return 1'b1;
    if (a == 2'b10) return 1'b0;
    if (a == 2'b01) return !p;
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_mod <= 0; m_act <= 0; m_lo <= 0; m_hi <= 0;
      m_ctl <= 0; m_glo <= 0; m_ghi <= 0; m_flag <= 0; m_pin <= 0;
    end else begin
      automatic bit at_top = (m_cnt == m_mod);
      automatic bit load   = m_glo && m_ghi && (!m_ctl[2] || at_top);
      automatic bit hit    = (m_cnt == m_act);
      automatic bit wc     = bus_we && bus_addr == 3'd2;
      automatic bit wl     = bus_we && bus_addr == 3'd4;
      automatic bit wh     = bus_we && bus_addr == 3'd5;
      m_cnt <= at_top ? 16'd0 : m_cnt + 16'd1;
      if (load) m_act <= {m_hi, m_lo};
      if (bus_we && bus_addr == 3'd0) m_mod[7:0]  <= bus_wdata;
      if (bus_we && bus_addr == 3'd1) m_mod[15:8] <= bus_wdata;
      if (wc) m_ctl <= bus_wdata[4:0];
      if (wl) m_lo <= bus_wdata;
      if (wh) m_hi <= bus_wdata;
      m_glo <= wc ? 1'b0 : (wl ? 1'b1 : (load ? 1'b0 : m_glo));
      m_ghi <= wc ? 1'b0 : (wh ? 1'b1 : (load ? 1'b0 : m_ghi));
      if (hit) m_flag <= 1'b1;
      else if (bus_we && bus_addr == 3'd3 && bus_wdata[0]) m_flag <= 1'b0;
      if (m_ctl[2]) m_pin <= (m_cnt < m_act) ? !m_ctl[3] : m_ctl[3];
      else if (hit) m_pin <= act_apply(m_pin, m_ctl[1:0]);
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(cnt_o == m_cnt, "R1 counter", cnt_o, m_cnt);
      check(ovf_o == (m_cnt == m_mod), "R1 overflow", ovf_o, m_cnt == m_mod);
      check(flag_o == m_flag, "R3 flag", flag_o, m_flag);
      check(irq_o == (m_flag && m_ctl[4]), "R4 irq", irq_o, m_flag && m_ctl[4]);
      if (m_ctl[2]) check(pin_o == m_pin, "R7 pwm pin", pin_o, m_pin);
      else          check(pin_o == m_pin, "R2 compare pin", pin_o, m_pin);
    end
  end

  // ---------------- stimulus helpers
  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_cnt(logic [15:0] v);
    do @(negedge clk); while (cnt_o != v);
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_o) hi++;
    end
  endtask

  initial begin : wdog
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int hi;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset values
    check(cnt_o == 0, "R10 reset counter", cnt_o, 0);
    check(pin_o == 0, "R10 reset pin", pin_o, 0);
    check(flag_o == 0, "R10 reset flag", flag_o, 0);
    check(irq_o == 0, "R10 reset irq", irq_o, 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);

    wait_cnt(0);
    wr(3'd0, 8'd9); wr(3'd1, 8'd0);      // modulus 9
    wr(3'd2, 8'h04);                     // PWM, polarity 0
    // R8 zero duty
    wait_cnt(0);
    count_high(20, hi);
    check(hi == 0, "R8 zero duty", hi, 0);
    wr(3'd4, 8'h10); wr(3'd5, 8'h00);    // value above modulus
    repeat (25) @(negedge clk);
    count_high(20, hi);
    check(hi == 20, "R8 full duty", hi, 20);

    // R9 mid-period pair waits for wrap
    wait_cnt(2);
    wr(3'd4, 8'd3); wr(3'd5, 8'd0);
    wait_cnt(7);
    check(pin_o == 1, "R9 old duty kept", pin_o, 1);
    wait_cnt(5);
    check(pin_o == 0, "R9 new duty after wrap", pin_o, 0);
    wait_cnt(2);
    check(pin_o == 1, "R9 new duty active part", pin_o, 1);

    // R6 control write discards half pair (compare mode, active value 3)
    wr(3'd4, 8'd5); wr(3'd2, 8'h00); wr(3'd5, 8'd0);
    wait_cnt(0); wr(3'd3, 8'h01);
    wait_cnt(4);
    check(flag_o == 1, "R6 half pair discarded", flag_o, 1);
    // R5 completing the pair loads value 5
    wr(3'd4, 8'd5);
    wait_cnt(0); wr(3'd3, 8'h01);
    wait_cnt(4);
    check(flag_o == 0, "R5 old value retired", flag_o, 0);
    wait_cnt(6);
    check(flag_o == 1, "R5 new value matches", flag_o, 1);

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      automatic int sel = $urandom % 10;
      if (sel < 6) begin
        case ($urandom % 6)
          0: if (cnt_o < 2) wr(3'd0, 8'(4 + $urandom % 12));
             else @(negedge clk);
          1: if (cnt_o < 2) wr(3'd1, 8'd0);
             else @(negedge clk);
          2: wr(3'd2, 8'($urandom % 32));
          3: wr(3'd3, 8'($urandom % 2));
          4: wr(3'd4, 8'($urandom % 18));
          default: wr(3'd5, 8'($urandom % 8 == 0 ? 1 : 0));
        endcase
      end else begin
        @(negedge clk);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule